// File: doc/BRIEF.md
# PCIe Configuration Window Translator

This block converts slave-bus accesses that land in a relocatable 64 KiB configuration window into configuration requests for a PCIe core. Software sets where the window sits in the address map. It also loads two 16-bit target identifiers, called slot 0 and slot 1, with one 32-bit write. Each identifier holds a bus number in its upper byte and a device/function number in its lower byte.

For each access the block picks an identifier, builds the core-side address and decides between a Type 0 and a Type 1 request. An access that does not decode becomes a miss item. The slave access enters on a valid/ready stream. The translated request leaves on a valid/ready stream through one output register.

Back-pressure works as follows. `s_ready` is high whenever the output register is empty or is being drained in the same cycle (`m_ready` high). A transfer happens on each rising edge where valid and ready are both high. While `m_valid` is high and `m_ready` is low, every `m_*` field holds its value.

The control register port is a plain port. Writes take effect on the clock edge. Reads are combinational from `reg_addr`.

Top module: `cfgwin_xlate`

## Requirements
- R1: After reset, `m_valid` is 0, `s_ready` is 1, and both registers read back as 0.
- R2: A write to offset 0x92C stores bits 31:16 as the window base. A read at 0x92C returns the base in bits 31:16 and zero in bits 15:0.
- R3: A write to offset 0x930 stores bits 15:0 as slot 0 and bits 31:16 as slot 1. A read at 0x930 returns {slot 1, slot 0}.
- R4: An access is a request only when `s_sel` is 1, address bits 31:16 equal the base, and window offset bits 15:13 are zero. Any other access produces an item with `m_miss`=1 and with `m_addr`, `m_be` and `m_type1` all zero.
- R5: `m_type1` is 0 when window offset bits 15:12 are all zero, and 1 otherwise.
- R6: A request's `m_addr` is {slot selected by offset bit 12 (0 selects slot 0), 4'b0000, offset bits 11:2, 2'b00}.
- R7: `m_be` is set from `s_size` (0 = byte, 1 = halfword, 2 or 3 = word) and address bits 1:0:
  - byte: `m_be` = 1 << addr[1:0]
  - halfword: `m_be` = addr[1] ? 4'b1100 : 4'b0011
  - word: `m_be` = 4'b1111
- R8: `m_write` and `m_wdata` carry the accepted `s_write` and `s_wdata` unchanged, for hits and misses alike.
- R9: Items leave in acceptance order. While `m_valid` is high and `m_ready` is low, `m_valid` stays high and the output fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| s_valid | input | 1 | Slave access valid |
| s_ready | output | 1 | Slave access ready |
| s_sel | input | 1 | Window hit indication from the interconnect |
| s_addr | input | 32 | Slave access address |
| s_write | input | 1 | Access is a write |
| s_size | input | 2 | Access size |
| s_wdata | input | 32 | Write data |
| m_valid | output | 1 | Request valid |
| m_ready | input | 1 | Core accepts the request |
| m_addr | output | 32 | Translated core address |
| m_type1 | output | 1 | 1 = Type 1 request, 0 = Type 0 |
| m_write | output | 1 | Request is a write |
| m_wdata | output | 32 | Pass-through data |
| m_be | output | 4 | Byte enables |
| m_miss | output | 1 | Access did not decode into a request |

## Verification
Two conditions are the hardest to reach from the ports. The first is a stalled output item that must stay frozen while the next access already waits at the input. The bench produces this with a repeating pattern that drops `m_ready` one cycle in three, and it sends accesses back to back. The second is the window boundary. The bench targets offsets 0x1FFC, 0x2000 and 0xFFFC, plus accesses just outside the base, to separate the R4 range test from the R5 type rule. The registers are rewritten between bursts, so each item's expected identifier comes from the register values in force when that item was accepted.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int WIN_W  = 16;               // 64 KiB window
  localparam int PAGE_W = 12;               // 4 KiB per identifier slot
  localparam int ID_W   = ADDR_W - WIN_W;   // identifier / base width
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_BASE = 12'h92C;
  localparam logic [REG_AW-1:0] OFS_ID   = 12'h930;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} acc_size_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              type1;
    logic              write;
    logic [DATA_W-1:0] wdata;
    logic [BE_W-1:0]   be;
    logic              miss;
  } cfg_req_t;
endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ID_W-1:0]   base,
  output logic [ID_W-1:0]   slot0,
  output logic [ID_W-1:0]   slot1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      slot0 <= '0;
      slot1 <= '0;
    end else if (we) begin
      if (addr == OFS_BASE) base <= wdata[DATA_W-1 -: ID_W];
      if (addr == OFS_ID) begin
        slot0 <= wdata[ID_W-1:0];
        slot1 <= wdata[DATA_W-1 -: ID_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_BASE) rdata = {base, {(DATA_W-ID_W){1'b0}}};
    else if (addr == OFS_ID) rdata = {slot1, slot0};
  end

  assert_base_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_BASE) |-> (rdata[WIN_W-1:0] == '0));

  assert_id_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_ID) |=> (slot0 == $past(wdata[ID_W-1:0])));
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
(
  input  logic [ID_W-1:0]   base,
  input  logic [ID_W-1:0]   slot0,
  input  logic [ID_W-1:0]   slot1,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output cfg_req_t          req
);
  logic [WIN_W-1:0] ofs;
  logic             in_win;
  logic [ID_W-1:0]  id;
  logic [BE_W-1:0]  be_raw;
  acc_size_e        sz;

  assign ofs    = addr[WIN_W-1:0];
  assign in_win = sel && (addr[ADDR_W-1 -: ID_W] == base) && (ofs[WIN_W-1:PAGE_W+1] == '0);
  assign id     = ofs[PAGE_W] ? slot1 : slot0;
  assign sz     = acc_size_e'(size);

  always_comb begin
    unique case (sz)
      SZ_BYTE: be_raw = BE_W'(1) << addr[1:0];
      SZ_HALF: be_raw = addr[1] ? 4'b1100 : 4'b0011;
      default: be_raw = '1;
    endcase
  end

  always_comb begin
    req.write = write;
    req.wdata = wdata;
    req.miss  = !in_win;
    if (in_win) begin
      req.addr  = {id, {(WIN_W-PAGE_W){1'b0}}, ofs[PAGE_W-1:2], 2'b00};
      req.type1 = (ofs[WIN_W-1:PAGE_W] != '0);
      req.be    = be_raw;
    end else begin
      req.addr  = '0;
      req.type1 = 1'b0;
      req.be    = '0;
    end
  end
endmodule

// File: rtl/cfgwin_outreg.sv
module cfgwin_outreg
  import cfgwin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  cfg_req_t in_req,
  output logic     out_valid,
  input  logic     out_ready,
  output cfg_req_t out_req
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_req   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_req <= in_req;
    end
  end

  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_req));
endmodule

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate
  import cfgwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic        s_sel,
  input  logic [31:0] s_addr,
  input  logic        s_write,
  input  logic [1:0]  s_size,
  input  logic [31:0] s_wdata,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [31:0] m_addr,
  output logic        m_type1,
  output logic        m_write,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_be,
  output logic        m_miss
);
  logic [ID_W-1:0] base, slot0, slot1;
  cfg_req_t        dec_req, out_req;

  cfgwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .base(base), .slot0(slot0), .slot1(slot1)
  );

  cfgwin_decode u_decode (
    .base(base), .slot0(slot0), .slot1(slot1), .sel(s_sel), .addr(s_addr),
    .write(s_write), .size(s_size), .wdata(s_wdata), .req(dec_req)
  );

  cfgwin_outreg u_outreg (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_ready), .in_req(dec_req),
    .out_valid(m_valid), .out_ready(m_ready), .out_req(out_req)
  );

  assign m_addr  = out_req.addr;
  assign m_type1 = out_req.type1;
  assign m_write = out_req.write;
  assign m_wdata = out_req.wdata;
  assign m_be    = out_req.be;
  assign m_miss  = out_req.miss;

  assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_miss) |-> (m_addr == '0 && m_be == '0 && !m_type1));

  assert_addr_gaps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_miss) |-> (m_addr[15:12] == 4'h0 && m_addr[1:0] == 2'b00));

  assert_be_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_miss) |-> ($countones(m_be) inside {1, 2, 4}));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);
endmodule

// File: tb/cfgwin_xlate_tb.sv
module cfgwin_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        s_sel = 1'b0;
  logic [31:0] s_addr = '0;
  logic        s_write = 1'b0;
  logic [1:0]  s_size = '0;
  logic [31:0] s_wdata = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [31:0] m_addr;
  logic        m_type1;
  logic        m_write;
  logic [31:0] m_wdata;
  logic [3:0]  m_be;
  logic        m_miss;

  int checks = 0;
  int failures = 0;
  bit run_ready = 1'b0;
  bit done = 1'b0;

  logic [15:0] mdl_base = '0, mdl_s0 = '0, mdl_s1 = '0;

  typedef struct packed {
    logic [31:0] addr; logic type1; logic write; logic [31:0] wdata; logic [3:0] be; logic miss;
  } exp_t;
  exp_t sb[$];

  always #HALF clk = ~clk;

  cfgwin_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .s_valid(s_valid), .s_ready(s_ready), .s_sel(s_sel),
    .s_addr(s_addr), .s_write(s_write), .s_size(s_size), .s_wdata(s_wdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_type1(m_type1),
    .m_write(m_write), .m_wdata(m_wdata), .m_be(m_be), .m_miss(m_miss)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input logic sel, input logic [31:0] a, input logic [1:0] sz,
                                 input logic wr, input logic [31:0] d);
    exp_t e;
    logic [15:0] o;
    o = a[15:0];
    e.write = wr;
    e.wdata = d;
    e.miss  = !(sel && a[31:16] == mdl_base && o < 16'h2000);
    if (e.miss) begin
      e.addr = '0; e.type1 = 1'b0; e.be = '0;
    end else begin
      e.type1 = (o[15:12] != 4'h0);
      e.addr  = {(o[12] ? mdl_s1 : mdl_s0), 4'h0, o[11:2], 2'b00};
      case (sz)
        2'd0:    e.be = 4'b0001 << a[1:0];
        2'd1:    e.be = a[1] ? 4'b1100 : 4'b0011;
        default: e.be = 4'b1111;
      endcase
    end
    return e;
  endfunction

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 12'h92C) mdl_base = d[31:16];
    if (a == 12'h930) begin mdl_s0 = d[15:0]; mdl_s1 = d[31:16]; end
  endtask

  task automatic reg_check(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // Driver: presents one access, pushes its expected item when the handshake occurs.
  task automatic send(input logic sel, input logic [31:0] a, input logic [1:0] sz,
                      input logic wr, input logic [31:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_sel = sel; s_addr = a; s_size = sz; s_write = wr; s_wdata = d;
    #(HALF-1);
    while (!s_ready) begin
      @(negedge clk);
      #(HALF-1);
    end
    sb.push_back(model(sel, a, sz, wr, d));
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // Back-pressure: drop ready one cycle in three.
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      m_ready = run_ready && ((cyc % 3) != 2);
      cyc++;
    end
  end

  // Monitor / scoreboard.
  initial begin
    bit stalled = 1'b0;
    logic [31:0] held_addr = '0;
    logic [31:0] held_data = '0;
    forever begin
      @(negedge clk);
      #(HALF-1);
      if (stalled && rst_n) begin
        check(m_valid == 1'b1, "R9 valid held under stall", {31'b0, m_valid}, 32'd1);
        check(m_addr == held_addr && m_wdata == held_data, "R9 fields held under stall", m_addr, held_addr);
      end
      stalled = 1'b0;
      if (m_valid && m_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected output item", m_addr, 32'hX);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(m_miss == e.miss, "R4 miss flag", {31'b0, m_miss}, {31'b0, e.miss});
          check(m_type1 == e.type1, "R5 request type", {31'b0, m_type1}, {31'b0, e.type1});
          check(m_addr == e.addr, "R6 translated address", m_addr, e.addr);
          check(m_be == e.be, "R7 byte enables", {28'b0, m_be}, {28'b0, e.be});
          check(m_write == e.write && m_wdata == e.wdata, "R8 data pass-through", m_wdata, e.wdata);
        end
      end else if (m_valid && !m_ready) begin
        stalled = 1'b1;
        held_addr = m_addr;
        held_data = m_wdata;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(m_valid == 1'b0, "R1 reset m_valid", {31'b0, m_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(s_ready == 1'b1, "R1 reset s_ready", {31'b0, s_ready}, 32'd1);
    reg_check(12'h92C, 32'h0, "R1 reset base");
    reg_check(12'h930, 32'h0, "R1 reset identifiers");

    reg_write(12'h92C, 32'hA000_1234);
    reg_check(12'h92C, 32'hA000_0000, "R2 base readback");
    reg_write(12'h930, 32'h0211_0108);
    reg_check(12'h930, 32'h0211_0108, "R3 identifier readback");

    run_ready = 1'b1;
    send(1'b1, 32'hA000_0004, 2'd2, 1'b0, 32'h0);
    send(1'b1, 32'hA000_1ABE, 2'd1, 1'b1, 32'hDEAD_BEEF);
    send(1'b1, 32'hA000_1003, 2'd0, 1'b1, 32'h1111_2222);
    send(1'b1, 32'hA000_0FFD, 2'd0, 1'b0, 32'h0);
    send(1'b1, 32'hA000_1FFC, 2'd3, 1'b0, 32'h0);
    send(1'b1, 32'hA000_2000, 2'd2, 1'b1, 32'h3333_4444);
    send(1'b1, 32'hA000_FFFC, 2'd2, 1'b0, 32'h0);
    send(1'b1, 32'hA001_0004, 2'd2, 1'b0, 32'h0);
    send(1'b0, 32'hA000_0008, 2'd2, 1'b1, 32'h5555_6666);
    send(1'b1, 32'hA000_0102, 2'd1, 1'b1, 32'h7777_8888);
    idle();
    repeat (6) @(negedge clk);

    reg_write(12'h930, 32'hFF80_0000);
    reg_write(12'h92C, 32'h1234_FFFF);
    reg_check(12'h92C, 32'h1234_0000, "R2 base rewrite");
    reg_check(12'h930, 32'hFF80_0000, "R3 identifier rewrite");
    send(1'b1, 32'h1234_0000, 2'd0, 1'b0, 32'h0);
    send(1'b1, 32'h1234_1FFE, 2'd1, 1'b1, 32'hCAFE_F00D);
    send(1'b1, 32'hA000_0004, 2'd2, 1'b0, 32'h0);
    send(1'b1, 32'h1234_1001, 2'd0, 1'b0, 32'h0);
    idle();

    repeat (50) begin
      if (sb.size() == 0) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R9 all items delivered", sb.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule